// File: doc/BRIEF.md
# Row Steering Sequencer

This block steers the row-by-row readout of a pixel matrix. For every row it drives one gate-select line and one clear line, and it emits two sample strobes that tell the readout front end when to capture the current before the clear pulse and when to capture it after. The timing of these events comes from a small sequence memory, which the host fills while the block is idle. After a start pulse the block walks through all of its rows without any further external control.

Each sequence entry describes one phase of a row. An entry selects which of the gate, clear and strobe lines are active, how many cycles the phase lasts, and whether the row is finished after this phase. A typical program asserts the gate, then fires the first strobe, then pulses clear while the gate stays on, then fires the second strobe, and then moves to the next row. When the last row is done the block raises a done flag and sends a one-cycle token. That token can start a second instance, so chained instances cover more rows than one instance has.

Top module: `rowseq_top`

## Requirements
- R1: While reset (rstN low) is applied and in the first cycle after it, all gate and clear lines, both strobes, busy, done and chainOut are low.
- R2: When busy is low, a write (wrEn high) stores wrData at entry wrAddr of the sequence memory. The layout of wrData is: bit 8 = gate, bit 7 = clear, bit 6 = sample A, bit 5 = sample B, bit 4 = row advance, bits 3:0 = hold count.
- R3: A start pulse sampled while idle sets busy in the following cycle and clears done. The block begins at row 0 with entry 0. The outputs of entry 0 appear one cycle after busy rises.
- R4: Each entry drives its outputs for exactly hold+1 consecutive cycles. The entries within a row follow in ascending order.
- R5: An entry ends its row after its hold time if its advance bit is set, or if it is entry 15. The next row starts again at entry 0.
- R6: gateRow and clearRow are registered. Each is either zero or one-hot on the current row, gateRow bit r being row r. When both are non-zero they select the same row.
- R7: sampleA and sampleB follow the sample A and sample B bits of the active entry, with the same timing as the gate line.
- R8: When row 63 finishes, chainOut is high for exactly one cycle, which is the final output cycle. In the next cycle all lines are low and busy is low. done then stays high until the next start.
- R9: start, chainIn and memory writes that arrive while busy is high have no effect on the running sequence or on the memory.
- R10: A chainIn pulse sampled while idle starts the block in the same way as start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse from the host |
| chainIn | input | 1 | Token from the previous instance |
| wrEn | input | 1 | Sequence memory write enable |
| wrAddr | input | 4 | Sequence memory entry index |
| wrData | input | 9 | Entry contents |
| gateRow | output | 64 | Per-row gate-select lines |
| clearRow | output | 64 | Per-row clear lines |
| sampleA | output | 1 | Strobe for the sample taken before clear |
| sampleB | output | 1 | Strobe for the sample taken after clear |
| busy | output | 1 | Sequencer is stepping rows |
| done | output | 1 | Last pass completed |
| chainOut | output | 1 | One-cycle token to the next instance |

## Verification
The bench tries several kinds of program. A directed gate/sample/clear/sample program shows that the phases come in the right order. A program with no advance bits shows that the row wraps at the final entry. A single long-hold entry exercises the full hold count. Random programs with mixed lengths and holds reveal errors in phase duration and row stepping. Some runs are started by chainIn instead of start. During some runs the bench injects stray start pulses and memory writes, which reveals any restart or corruption of the program in use.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
  localparam int HOLD_W = 4;

  // One phase of a row's micro-sequence
  typedef struct packed {
    logic              gate;
    logic              clr;
    logic              smpA;
    logic              smpB;
    logic              adv;
    logic [HOLD_W-1:0] hold;
  } seqEntry_t;

  localparam int ENTRY_W = $bits(seqEntry_t);

  // Strobes from control to datapath
  typedef struct packed {
    logic active;
    logic finish;
  } ctrlStrb_t;
endpackage

// File: rtl/rowseq_ctrl.sv
module rowseq_ctrl
  import rowseq_pkg::*;
#(
  parameter int NUM_ROWS  = 64,
  parameter int SEQ_DEPTH = 16,
  localparam int ROW_W    = $clog2(NUM_ROWS),
  localparam int STEP_W   = $clog2(SEQ_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              chainIn,
  input  logic [HOLD_W-1:0] curHold,
  input  logic              curAdv,
  output ctrlStrb_t         strb,
  output logic [ROW_W-1:0]  rowIdx,
  output logic [STEP_W-1:0] stepIdx,
  output logic              busy,
  output logic              done
);
  logic              active;
  logic [HOLD_W-1:0] holdCnt;
  logic              phaseEnd, rowEnd, lastRow;

  assign phaseEnd = (holdCnt == curHold);
  assign rowEnd   = phaseEnd && (curAdv || stepIdx == STEP_W'(SEQ_DEPTH-1));
  assign lastRow  = (rowIdx == ROW_W'(NUM_ROWS-1));

  assign strb.active = active;
  assign strb.finish = active && rowEnd && lastRow;
  assign busy        = active;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      done    <= 1'b0;
      rowIdx  <= '0;
      stepIdx <= '0;
      holdCnt <= '0;
    end else if (!active) begin
      if (start || chainIn) begin
        active  <= 1'b1;
        done    <= 1'b0;
        rowIdx  <= '0;
        stepIdx <= '0;
        holdCnt <= '0;
      end
    end else if (!phaseEnd) begin
      holdCnt <= holdCnt + 1'b1;
    end else begin
      holdCnt <= '0;
      if (rowEnd) begin
        stepIdx <= '0;
        if (lastRow) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          rowIdx <= rowIdx + 1'b1;
        end
      end else begin
        stepIdx <= stepIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rowseq_dp.sv
module rowseq_dp
  import rowseq_pkg::*;
#(
  parameter int NUM_ROWS  = 64,
  parameter int SEQ_DEPTH = 16,
  localparam int ROW_W    = $clog2(NUM_ROWS),
  localparam int STEP_W   = $clog2(SEQ_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [ROW_W-1:0]   rowIdx,
  input  logic [STEP_W-1:0]  stepIdx,
  input  logic               wrEn,
  input  logic [STEP_W-1:0]  wrAddr,
  input  logic [ENTRY_W-1:0] wrData,
  output logic [HOLD_W-1:0]  curHold,
  output logic               curAdv,
  output logic [NUM_ROWS-1:0] gateRow,
  output logic [NUM_ROWS-1:0] clearRow,
  output logic               sampleA,
  output logic               sampleB,
  output logic               chainOut
);
  seqEntry_t         seqMem [SEQ_DEPTH];
  seqEntry_t         cur;
  logic [NUM_ROWS-1:0] rowHit;

  assign cur     = seqMem[stepIdx];
  assign curHold = cur.hold;
  assign curAdv  = cur.adv;

  // Sequence memory: host writes accepted only while halted
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SEQ_DEPTH; i++) seqMem[i] <= '0;
    end else if (wrEn && !strb.active) begin
      seqMem[wrAddr] <= seqEntry_t'(wrData);
    end
  end

  // Row decode, one comparator per row
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_rowDec
    assign rowHit[r] = (rowIdx == ROW_W'(r));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateRow  <= '0;
      clearRow <= '0;
      sampleA  <= 1'b0;
      sampleB  <= 1'b0;
      chainOut <= 1'b0;
    end else begin
      gateRow  <= (strb.active && cur.gate) ? rowHit : '0;
      clearRow <= (strb.active && cur.clr)  ? rowHit : '0;
      sampleA  <= strb.active && cur.smpA;
      sampleB  <= strb.active && cur.smpB;
      chainOut <= strb.finish;
    end
  end
endmodule

// File: rtl/rowseq_top.sv
module rowseq_top
  import rowseq_pkg::*;
#(
  parameter int NUM_ROWS  = 64,
  parameter int SEQ_DEPTH = 16,
  localparam int ROW_W    = $clog2(NUM_ROWS),
  localparam int STEP_W   = $clog2(SEQ_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                chainIn,
  input  logic                wrEn,
  input  logic [STEP_W-1:0]   wrAddr,
  input  logic [ENTRY_W-1:0]  wrData,
  output logic [NUM_ROWS-1:0] gateRow,
  output logic [NUM_ROWS-1:0] clearRow,
  output logic                sampleA,
  output logic                sampleB,
  output logic                busy,
  output logic                done,
  output logic                chainOut
);
  ctrlStrb_t         strb;
  logic [ROW_W-1:0]  rowIdx;
  logic [STEP_W-1:0] stepIdx;
  logic [HOLD_W-1:0] curHold;
  logic              curAdv;

  rowseq_ctrl #(.NUM_ROWS(NUM_ROWS), .SEQ_DEPTH(SEQ_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .chainIn(chainIn),
    .curHold(curHold), .curAdv(curAdv), .strb(strb),
    .rowIdx(rowIdx), .stepIdx(stepIdx), .busy(busy), .done(done)
  );

  rowseq_dp #(.NUM_ROWS(NUM_ROWS), .SEQ_DEPTH(SEQ_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rowIdx(rowIdx), .stepIdx(stepIdx),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .curHold(curHold), .curAdv(curAdv),
    .gateRow(gateRow), .clearRow(clearRow),
    .sampleA(sampleA), .sampleB(sampleB), .chainOut(chainOut)
  );
endmodule

// File: rtl/rowseq_chk.sv
module rowseq_chk #(
  parameter int NUM_ROWS = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                chainIn,
  input logic [NUM_ROWS-1:0] gateRow,
  input logic [NUM_ROWS-1:0] clearRow,
  input logic                sampleA,
  input logic                sampleB,
  input logic                busy,
  input logic                done,
  input logic                chainOut
);
  assert_gate_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gateRow));

  assert_clear_same_row_R6: assert property (@(posedge clk) disable iff (!rstN)
    (gateRow != '0 && clearRow != '0) |-> (gateRow == clearRow));

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (start || chainIn)) |=> busy);

  assert_chain_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    chainOut |=> !chainOut);

  assert_fall_with_token_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> chainOut);

  assert_quiet_after_token_R8: assert property (@(posedge clk) disable iff (!rstN)
    chainOut |=> (gateRow == '0 && clearRow == '0 && !sampleA && !sampleB));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind rowseq_top rowseq_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .chainIn(chainIn),
  .gateRow(gateRow), .clearRow(clearRow), .sampleA(sampleA),
  .sampleB(sampleB), .busy(busy), .done(done), .chainOut(chainOut)
);

// File: tb/rowseq_top_test.sv
`timescale 1ns/1ps
module rowseq_top_test;
  localparam int NR = 64;
  localparam int SD = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0, chainIn = 1'b0, wrEn = 1'b0;
  logic [3:0]    wrAddr = '0;
  logic [8:0]    wrData = '0;
  logic [NR-1:0] gateRow, clearRow;
  logic          sampleA, sampleB, busy, done, chainOut;

  int checks = 0, errors = 0;
  logic [8:0] prog [SD];

  always #2.5 clk = ~clk;

  rowseq_top uut (
    .clk(clk), .rstN(rstN), .start(start), .chainIn(chainIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .gateRow(gateRow), .clearRow(clearRow), .sampleA(sampleA),
    .sampleB(sampleB), .busy(busy), .done(done), .chainOut(chainOut)
  );

  function automatic logic [8:0] mkEnt(bit g, bit c, bit a, bit b, bit adv, int hold);
    return {g, c, a, b, adv, 4'(hold)};
  endfunction

  function automatic logic [NR-1:0] rowVec(bit on, int r);
    return on ? (NR'(1) << r) : '0;
  endfunction

  task automatic check(bit ok, string req, logic [NR-1:0] act, logic [NR-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeEnt(int addr, logic [8:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    prog[addr] = data;
  endtask

  // Run one pass and compare every output cycle with the program model
  task automatic runPass(bit useChain, bit disturb);
    bit last;
    @(negedge clk);
    if (useChain) chainIn = 1'b1; else start = 1'b1;
    @(negedge clk);
    chainIn = 1'b0; start = 1'b0;
    check(busy == 1'b1, useChain ? "R10 busy after token" : "R3 busy after start", NR'(busy), NR'(1));
    check(done == 1'b0, "R3 done cleared", NR'(done), '0);
    check(gateRow == '0, "R3 gate latency", gateRow, '0);
    for (int r = 0; r < NR; r++) begin
      for (int s = 0; s < SD; s++) begin
        logic [8:0] e;
        bit endRow;
        e = prog[s];
        endRow = e[4] || (s == SD-1);
        for (int c = 0; c <= int'(e[3:0]); c++) begin
          last = (r == NR-1) && endRow && (c == int'(e[3:0]));
          @(negedge clk);
          check(gateRow == rowVec(e[8], r), "R5 gate row", gateRow, rowVec(e[8], r));
          check(clearRow == rowVec(e[7], r), "R6 clear row", clearRow, rowVec(e[7], r));
          check(sampleA == e[6], "R7 sampleA", NR'(sampleA), NR'(e[6]));
          check(sampleB == e[5], "R7 sampleB", NR'(sampleB), NR'(e[5]));
          check(chainOut == last, "R8 chainOut", NR'(chainOut), NR'(last));
          check(busy == !last, "R4 busy", NR'(busy), NR'(!last));
          if (disturb && !last) begin
            start   = ($urandom % 40) == 0;
            chainIn = ($urandom % 40) == 0;
            wrEn    = ($urandom % 8) == 0;
            wrAddr  = 4'($urandom);
            wrData  = 9'($urandom);
          end else begin
            start = 1'b0; chainIn = 1'b0; wrEn = 1'b0;
          end
        end
        if (endRow) break;
      end
    end
    start = 1'b0; chainIn = 1'b0; wrEn = 1'b0;
    @(negedge clk);
    check(gateRow == '0 && clearRow == '0, "R8 lines low", gateRow | clearRow, '0);
    check(!sampleA && !sampleB && !chainOut, "R8 strobes low", NR'({sampleA, sampleB, chainOut}), '0);
    check(busy == 1'b0, "R8 busy low", NR'(busy), '0);
    check(done == 1'b1, "R8 done high", NR'(done), NR'(1));
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R8 done held", NR'(done), NR'(1));
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < SD; i++) prog[i] = '0;
    repeat (3) @(negedge clk);
    check(gateRow == '0 && clearRow == '0, "R1 lines in reset", gateRow | clearRow, '0);
    check(!busy && !done && !chainOut && !sampleA && !sampleB, "R1 flags in reset",
          NR'({busy, done, chainOut, sampleA, sampleB}), '0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && gateRow == '0, "R1 after reset", NR'({busy, done}) | gateRow, '0);

    // Directed: gate, sample A, clear, sample B, advance (R2 layout)
    writeEnt(0, mkEnt(1, 0, 0, 0, 0, 1));
    writeEnt(1, mkEnt(1, 0, 1, 0, 0, 0));
    writeEnt(2, mkEnt(1, 1, 0, 0, 0, 2));
    writeEnt(3, mkEnt(1, 0, 0, 1, 1, 0));
    runPass(0, 0);
    // Same program again under stray start/chainIn/writes (R9)
    runPass(0, 1);
    runPass(0, 0);

    // No advance bits: row ends at entry 15 (R5)
    for (int i = 0; i < SD; i++) writeEnt(i, mkEnt(i[0], i[1], i[2], i[3], 0, 0));
    runPass(1, 0);

    // Longest hold in a single entry (R4)
    writeEnt(0, mkEnt(1, 1, 1, 1, 1, 15));
    runPass(0, 0);

    // Random programs
    for (int t = 0; t < 8; t++) begin
      int len;
      len = 1 + ($urandom % 6);
      for (int i = 0; i < len; i++)
        writeEnt(i, mkEnt($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                          i == len-1, $urandom % 4));
      runPass(t % 2, t >= 4);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule